// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pairwise Accumulate

This unit multiplies two 64-bit operands lane by lane. Each operand carries four signed 16-bit lanes, and every lane of `a_i` is multiplied by the lane of `b_i` in the same position. A 2-bit mode picks what is returned from the four 32-bit signed products:

- the upper half of each product, one per lane;
- the lower half of each product, one per lane;
- two 32-bit sums, each formed from a pair of neighbouring products.

The unit has two pipeline stages. The first stage registers the four products together with the mode. The second stage selects or sums and registers the 64-bit result. An operation is presented with `valid_i` high, and it may be presented on every cycle. The result appears with `valid_o` two clocks later. Typical uses are fixed-point scaling, where the upper half is wanted, and short dot products such as filter taps.

Top module: `pmul16_unit`

## Requirements
- R1: Mode 0 (upper half): result lane i, at bits 16*i+15..16*i, holds bits 31..16 of the signed 32-bit product a_i lane i × b_i lane i. Lane i of each operand is bits 16*i+15..16*i, read as two's complement.
- R2: Mode 1 (lower half): result lane i holds bits 15..0 of the signed product of lane i.
- R3: Mode 2 (pairwise sum): result bits 63..32 equal product3 + product2, and bits 31..0 equal product1 + product0. Each sum is taken modulo 2^32, so four lanes of -32768 give 0x80000000 in both halves.
- R4: Mode 3 is unused and returns an all-zero result.
- R5: `valid_o` is high exactly two rising edges after the edge that sampled `valid_i` high. A new operation is accepted on every cycle, with no bubbles.
- R6: The mode is captured alongside its operands. Back-to-back operations with different modes each complete in their own mode.
- R7: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R8: `result_o` keeps its last value in every cycle where `valid_o` is low.
- R9: The product (-32768)×(-32768) = 0x40000000 is exact. Its upper half is 0x4000 and its lower half is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on a_i, b_i and mode_i |
| mode_i | input | 2 | 0 upper half, 1 lower half, 2 pairwise sum, 3 zero |
| a_i | input | 64 | First operand, four signed 16-bit lanes |
| b_i | input | 64 | Second operand, four signed 16-bit lanes |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Result |

## Verification
The bench targets the cases a flawed design would get wrong:

- **Most negative lane values.** If a lane were extended as unsigned, the upper halves would be wrong whenever a lane is negative. If the pairwise sum saturated instead of wrapping, four -32768 lanes would give 0x7FFFFFFF instead of 0x80000000.
- **Mode changing on every cycle.** The bench issues operations back to back with a different mode each time. If the mode were not pipelined alongside the operands, each result would be decoded with its neighbour's mode.
- **Idle gaps.** Gaps are mixed into the stream to show up a wrong valid latency or a result that drifts while `valid_o` is low.
- **Mode 3.** This is checked for an all-zero output.

// File: rtl/pmul16_pkg.sv
package pmul16_pkg;
  typedef enum logic [1:0] {
    MODE_HI   = 2'd0,
    MODE_LO   = 2'd1,
    MODE_MADD = 2'd2,
    MODE_RSV  = 2'd3
  } pmul_mode_e;
endpackage

// File: rtl/pmul16_lane_mul.sv
module pmul16_lane_mul #(
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod_d;

  assign a_ext  = PROD_W'($signed(a_i));
  assign b_ext  = PROD_W'($signed(b_i));
  assign prod_d = a_ext * b_ext;  // exact in PROD_W for signed LANE_W inputs

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_o <= '0;
    else if (en_i) prod_o <= prod_d;
  end
endmodule

// File: rtl/pmul16_combine.sv
module pmul16_combine
  import pmul16_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W,
  localparam int PAIRS  = LANES / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  pmul_mode_e              mode_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  output logic [DATA_W-1:0]       result_o
);
  logic [DATA_W-1:0] hi_w, lo_w, madd_w, res_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hi_w[l*LANE_W +: LANE_W] = prod_i[l*PROD_W + LANE_W +: LANE_W];
    assign lo_w[l*LANE_W +: LANE_W] = prod_i[l*PROD_W +: LANE_W];
  end

  // pair sums wrap in PROD_W
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign madd_w[p*PROD_W +: PROD_W] = prod_i[(2*p)*PROD_W +: PROD_W]
                                      + prod_i[(2*p+1)*PROD_W +: PROD_W];
  end

  always_comb begin
    unique case (mode_i)
      MODE_HI:   res_d = hi_w;
      MODE_LO:   res_d = lo_w;
      MODE_MADD: res_d = madd_w;
      default:   res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_o <= '0;
    else if (en_i) result_o <= res_d;
  end
endmodule

// File: rtl/pmul16_unit.sv
module pmul16_unit
  import pmul16_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic                    s1_vld_q;
  pmul_mode_e              s1_mode_q;
  logic [LANES*PROD_W-1:0] s1_prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_mode_q <= MODE_HI;
      valid_o   <= 1'b0;
    end else begin
      s1_vld_q <= valid_i;
      valid_o  <= s1_vld_q;
      if (valid_i) s1_mode_q <= pmul_mode_e'(mode_i);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    pmul16_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .prod_o (s1_prod[l*PROD_W +: PROD_W])
    );
  end

  pmul16_combine #(.LANE_W(LANE_W), .LANES(LANES)) u_combine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (s1_vld_q),
    .mode_i   (s1_mode_q),
    .prod_i   (s1_prod),
    .result_o (result_o)
  );

  // ---- assertions ----
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  function automatic logic [PROD_W-1:0] smul(logic [LANE_W-1:0] x, logic [LANE_W-1:0] y);
    logic signed [PROD_W-1:0] xe, ye;
    xe = PROD_W'($signed(x));
    ye = PROD_W'($signed(y));
    return xe * ye;
  endfunction

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R1
  hi_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o && $past(mode_i, 2) == 2'd0) |->
    result_o[LANE_W-1:0] ==
      smul($past(a_i[LANE_W-1:0], 2), $past(b_i[LANE_W-1:0], 2))[PROD_W-1:LANE_W]);

  // R2
  lo_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o && $past(mode_i, 2) == 2'd1) |->
    result_o[LANE_W-1:0] ==
      smul($past(a_i[LANE_W-1:0], 2), $past(b_i[LANE_W-1:0], 2))[LANE_W-1:0]);

  // R3
  madd_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o && $past(mode_i, 2) == 2'd2) |->
    result_o[PROD_W-1:0] ==
      smul($past(a_i[LANE_W-1:0], 2), $past(b_i[LANE_W-1:0], 2))
    + smul($past(a_i[2*LANE_W-1:LANE_W], 2), $past(b_i[2*LANE_W-1:LANE_W], 2)));

  // R4
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o && $past(mode_i, 2) == 2'd3) |-> result_o == '0);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !valid_o) |-> $stable(result_o));
endmodule

// File: tb/pmul16_unit_bench.sv
module pmul16_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] a = '0, b = '0;
  logic        vo;
  logic [63:0] res;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit running = 1'b0, done = 1'b0;

  logic [63:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];
  logic [63:0] last_out;
  bit          have_out = 1'b0;

  pmul16_unit u_pmul16_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .mode_i(mode),
    .a_i(a), .b_i(b), .valid_o(vo), .result_o(res)
  );

  always #2ns clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [63:0] model(logic [1:0] m, logic [63:0] x, logic [63:0] y);
    logic signed [31:0] p [4];
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++)
      p[i] = 32'($signed(x[16*i +: 16])) * 32'($signed(y[16*i +: 16]));
    case (m)
      2'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
      2'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
      2'd2: begin r[31:0] = p[0] + p[1]; r[63:32] = p[2] + p[3]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic send(logic [1:0] m, logic [63:0] x, logic [63:0] y, string tag);
    @(negedge clk);
    vld = 1'b1; mode = m; a = x; b = y;
    exp_q.push_back(model(m, x, y));
    due_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0; a = 64'hdead_beef_0bad_f00d; mode = 2'd2;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (vo) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5 act=valid_o=1 exp=no pending result");
        end else begin
          check(tag_q.pop_front(), res, exp_q.pop_front());
          check("R5", 64'(cyc), 64'(due_q.pop_front()));
        end
        last_out = res; have_out = 1'b1;
      end else begin
        if (due_q.size() > 0 && due_q[0] <= cyc) begin
          check("R5", 64'(0), 64'(1));  // expected valid_o=1 here
          void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end
        if (have_out) check("R8", res, last_out);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    logic [63:0] x, y;
    logic [1:0]  m;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R7", {63'd0, vo}, 64'd0);
    check("R7", res, 64'd0);
    rst_n = 1'b1;
    running = 1'b1;

    // R1 mixed signs and extremes
    send(2'd0, 64'h7fff_8000_0003_fffe, 64'h7fff_8000_fffd_0002, "R1");
    // R2
    send(2'd1, 64'h1234_8001_ffff_00ff, 64'h5678_7fff_ffff_0101, "R2");
    // R9 min*min in both halves
    send(2'd0, {4{16'h8000}}, {4{16'h8000}}, "R9");
    send(2'd1, {4{16'h8000}}, {4{16'h8000}}, "R9");
    // R3 wrap to 0x80000000
    send(2'd2, {4{16'h8000}}, {4{16'h8000}}, "R3");
    send(2'd2, 64'h7fff_7fff_8000_7fff, 64'h7fff_7fff_7fff_8000, "R3");
    // R4
    send(2'd3, 64'hffff_ffff_ffff_ffff, 64'h1111_2222_3333_4444, "R4");
    idle(3);
    // R6 mode switching every cycle on the same operands
    for (int k = 0; k < 3; k++) begin
      send(2'd0, 64'h9abc_4321_8765_0f0f, 64'hc001_7ff0_0123_f0f0, "R6");
      send(2'd1, 64'h9abc_4321_8765_0f0f, 64'hc001_7ff0_0123_f0f0, "R6");
      send(2'd2, 64'h9abc_4321_8765_0f0f, 64'hc001_7ff0_0123_f0f0, "R6");
      send(2'd3, 64'h9abc_4321_8765_0f0f, 64'hc001_7ff0_0123_f0f0, "R6");
    end
    idle(2);
    // random stream with gaps (R5 throughput and latency)
    for (int k = 0; k < 80; k++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      m = 2'($urandom_range(0, 3));
      send(m, x, y, mtag(m));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(6);
    check("R5", 64'(exp_q.size()), 64'd0);
    running = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule